// File: doc/BRIEF.md
# Multiplexed-Address Dynamic Memory Sequencer

This block drives a 64K-byte store made of eight 64K x 1 dynamic RAM devices, one device for each bit of a byte. The devices have only eight address pins. Each access therefore presents the upper address byte as a row and latches it with an active-low row strobe. It then presents the lower address byte as a column and latches it with an active-low column strobe. A write holds the active-low write enable during the column phase. A read captures the returned byte one cycle after the column strobe falls.

A requester raises `req_i` with the address, the direction and the write byte, and holds them until `ack_o` pulses. The block keeps its own refresh timer and a 7-bit row counter. Every interval it runs a refresh that strobes the row only, with the column strobe held high, at the next counter row. A refresh that is due is served before the next request. An access already under way always completes first.

Top module: `dram_ctrl`

## Requirements
- R1: While `rst_ni` is low, and afterwards until the first refresh, `ras_no`, `cas_no` and `we_no` are high and `ack_o` is low.
- R2: An access takes one cycle with `ras_no` low, `cas_no` high and `ma_o` = `addr_i[15:8]`. It is followed by exactly one cycle with both strobes low and `ma_o` = `addr_i[7:0]`. `cas_no` is never low while `ras_no` is high.
- R3: In a write, `we_no` is low and `d_o` equals the write byte in the cycle where `cas_no` is low. `we_no` is high in every other cycle and throughout reads.
- R4: `ack_o` is high for exactly one cycle, the cycle after the column-strobe cycle. For reads, `rdata_o` then holds the byte on `q_i` at the end of the column-strobe cycle.
- R5: When no requests arrive, refresh cycles start exactly REF_CYCLES (default 80) clocks apart.
- R6: A refresh is one cycle with `ras_no` low and `cas_no` high. In that cycle `ma_o[6:0]` is the refresh row and `ma_o[7]` is 0. The row starts at 0 after reset, steps by one per refresh, and wraps from 127 to 0.
- R7: A pending refresh is taken before any new request, even when `req_i` stays high continuously. It never starts while an access is in progress.
- R8: After every row-strobe period, `ras_no` stays high for at least one cycle before it falls again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request, held until ack |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 16 | Byte address |
| wdata_i | input | 8 | Write byte |
| ack_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | 8 | Read byte, valid with ack |
| ma_o | output | 8 | Multiplexed memory address |
| ras_no | output | 1 | Row strobe, active low |
| cas_no | output | 1 | Column strobe, active low |
| we_no | output | 1 | Write enable, active low |
| d_o | output | 8 | Data to the devices |
| q_i | input | 8 | Data from the devices |

## Verification
A behavioural device model in the bench latches the row and column on the strobe edges, stores and returns bytes, and a scoreboard compares every completed access. The patterns used are all-zero, all-one and alternating addresses. A wrong row/column split shows up as corrupted readback rather than passing by symmetry. Long idle stretches check the exact refresh spacing and the row wrap at 127. A burst of back-to-back requests with the request line never dropped tells whether refresh outranks accesses or is starved by them. Reads of unwritten locations check that readback is not stale data left on the bus.

// File: rtl/dram_ctrl_pkg.sv
package dram_ctrl_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ROW,
    ST_COL,
    ST_PRE,
    ST_REF
  } seq_state_e;

  typedef enum logic [1:0] {
    MA_ROW,
    MA_COL,
    MA_REF
  } ma_sel_e;
endpackage

// File: rtl/dram_refresh_timer.sv
module dram_refresh_timer #(
  parameter int CYCLES = 80,
  parameter int ROWS   = 128,
  localparam int CNT_W = $clog2(CYCLES),
  localparam int ROW_W = $clog2(ROWS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             take_i,
  input  logic             done_i,
  output logic             pend_o,
  output logic [ROW_W-1:0] row_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [ROW_W-1:0] row_q;
  logic             pend_q;
  logic             expire;

  assign expire = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= CNT_W'(CYCLES - 1);
    end else if (expire) begin
      cnt_q <= CNT_W'(CYCLES - 1);
    end else begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  // set wins over take so a due interval is never lost
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      pend_q <= 1'b0;
    else if (expire)  pend_q <= 1'b1;
    else if (take_i)  pend_q <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      row_q <= '0;
    end else if (done_i) begin
      row_q <= (row_q == ROW_W'(ROWS - 1)) ? '0 : row_q + 1'b1;
    end
  end

  assign pend_o = pend_q;
  assign row_o  = row_q;

  a_r5_expire_sets_pend : assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire |=> pend_q);

  a_r6_row_moves_on_done : assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> (row_q != $past(row_q)));

  a_r6_row_holds : assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_i |=> $stable(row_q));
endmodule

// File: rtl/dram_addr_mux.sv
module dram_addr_mux
  import dram_ctrl_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int MA_W   = 8,
  parameter int ROW_W  = 7
) (
  input  ma_sel_e           sel_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [ROW_W-1:0]  ref_row_i,
  output logic [MA_W-1:0]   ma_o
);
  logic [MA_W-1:0] row_part;
  logic [MA_W-1:0] col_part;
  logic [MA_W-1:0] ref_part;

  assign row_part = addr_i[ADDR_W-1 -: MA_W];
  assign col_part = addr_i[MA_W-1:0];

  generate
    if (ROW_W < MA_W) begin : g_pad
      assign ref_part = {{(MA_W - ROW_W){1'b0}}, ref_row_i};
    end else begin : g_trim
      assign ref_part = ref_row_i[MA_W-1:0];
    end
  endgenerate

  always_comb begin
    unique case (sel_i)
      MA_ROW:  ma_o = row_part;
      MA_COL:  ma_o = col_part;
      MA_REF:  ma_o = ref_part;
      default: ma_o = '0;
    endcase
  end
endmodule

// File: rtl/dram_seq.sv
module dram_seq
  import dram_ctrl_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              ref_pend_i,
  input  logic [DATA_W-1:0] q_i,
  output logic              ref_take_o,
  output logic              ref_done_o,
  output ma_sel_e           ma_sel_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              ras_no,
  output logic              cas_no,
  output logic              we_no,
  output logic [DATA_W-1:0] d_o,
  output logic              ack_o,
  output logic [DATA_W-1:0] rdata_o
);
  seq_state_e        state_q, state_d;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;
  logic              we_q, ack_q;
  logic              accept;

  assign ref_take_o = (state_q == ST_IDLE) && ref_pend_i;
  assign accept     = (state_q == ST_IDLE) && !ref_pend_i && req_i;
  assign ref_done_o = (state_q == ST_REF);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (ref_pend_i)  state_d = ST_REF;
        else if (req_i)  state_d = ST_ROW;
      end
      ST_ROW:  state_d = ST_COL;
      ST_COL:  state_d = ST_PRE;
      ST_PRE:  state_d = ST_IDLE;
      ST_REF:  state_d = ST_PRE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      wdata_q <= '0;
      we_q    <= 1'b0;
    end else if (accept) begin
      addr_q  <= addr_i;
      wdata_q <= wdata_i;
      we_q    <= we_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      ack_q <= (state_q == ST_COL);
      if (state_q == ST_COL && !we_q) rdata_q <= q_i;
    end
  end

  always_comb begin
    unique case (state_q)
      ST_COL:  ma_sel_o = MA_COL;
      ST_REF:  ma_sel_o = MA_REF;
      default: ma_sel_o = MA_ROW;
    endcase
  end

  assign ras_no  = !(state_q == ST_ROW || state_q == ST_COL || state_q == ST_REF);
  assign cas_no  = !(state_q == ST_COL);
  assign we_no   = !((state_q == ST_COL) && we_q);
  assign d_o     = wdata_q;
  assign addr_o  = addr_q;
  assign ack_o   = ack_q;
  assign rdata_o = rdata_q;

  a_r2_cas_inside_ras : assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cas_no |-> !ras_no);

  a_r2_ras_before_cas : assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ras_no) |-> cas_no);

  a_r3_we_only_in_col : assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_no |-> !cas_no);

  a_r4_ack_single : assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |=> !ack_o);

  a_r4_ack_after_col : assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cas_no |=> ack_o);

  a_r7_refresh_first : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && ref_pend_i) |=> (state_q == ST_REF));

  a_r8_precharge : assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ras_no) |=> ras_no);
endmodule

// File: rtl/dram_ctrl.sv
module dram_ctrl
  import dram_ctrl_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 8,
  parameter int MA_W       = 8,
  parameter int REF_ROWS   = 128,
  parameter int REF_CYCLES = 80
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              ack_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic [MA_W-1:0]   ma_o,
  output logic              ras_no,
  output logic              cas_no,
  output logic              we_no,
  output logic [DATA_W-1:0] d_o,
  input  logic [DATA_W-1:0] q_i
);
  localparam int ROW_W = $clog2(REF_ROWS);

  logic              ref_pend, ref_take, ref_done;
  logic [ROW_W-1:0]  ref_row;
  logic [ADDR_W-1:0] addr_lat;
  ma_sel_e           ma_sel;

  dram_refresh_timer #(
    .CYCLES (REF_CYCLES),
    .ROWS   (REF_ROWS)
  ) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .take_i (ref_take),
    .done_i (ref_done),
    .pend_o (ref_pend),
    .row_o  (ref_row)
  );

  dram_seq #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (req_i),
    .we_i       (we_i),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .ref_pend_i (ref_pend),
    .q_i        (q_i),
    .ref_take_o (ref_take),
    .ref_done_o (ref_done),
    .ma_sel_o   (ma_sel),
    .addr_o     (addr_lat),
    .ras_no     (ras_no),
    .cas_no     (cas_no),
    .we_no      (we_no),
    .d_o        (d_o),
    .ack_o      (ack_o),
    .rdata_o    (rdata_o)
  );

  dram_addr_mux #(
    .ADDR_W (ADDR_W),
    .MA_W   (MA_W),
    .ROW_W  (ROW_W)
  ) u_mux (
    .sel_i     (ma_sel),
    .addr_i    (addr_lat),
    .ref_row_i (ref_row),
    .ma_o      (ma_o)
  );
endmodule

// File: tb/dram_ctrl_test.sv
module dram_ctrl_test;
  localparam int REF_CYCLES = 80;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0;
  logic        we_i = 1'b0;
  logic [15:0] addr_i = '0;
  logic [7:0]  wdata_i = '0;
  logic [7:0]  q_i = '0;
  logic        ack_o, ras_no, cas_no, we_no;
  logic [7:0]  rdata_o, ma_o, d_o;

  always #2 clk_i = ~clk_i;

  dram_ctrl uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .ack_o(ack_o), .rdata_o(rdata_o),
    .ma_o(ma_o), .ras_no(ras_no), .cas_no(cas_no), .we_no(we_no),
    .d_o(d_o), .q_i(q_i)
  );

  typedef struct {
    logic        we;
    logic [15:0] addr;
    logic [7:0]  wdata;
    logic [7:0]  exp;
  } item_t;

  item_t      sbq[$];
  logic [7:0] shadow[int];
  logic [7:0] dev[int];
  int         n_tests = 0, n_fail = 0;
  longint     cyc = 0;
  int         ref_count = 0;
  logic [6:0] exp_row = '0;
  bit         gap_on = 0;
  longint     last_ref = -1;
  bit         done = 0;

  always @(posedge clk_i) cyc++;

  function automatic void chk(bit ok, string req, string what, longint act, longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endfunction

  function automatic logic [7:0] dev_rd(int a);
    return dev.exists(a) ? dev[a] : 8'h00;
  endfunction

  // device model and monitor
  logic       prev_ras = 1'b1, prev_ack = 1'b0;
  bit         phase1 = 0;
  logic [7:0] row_rec, row_l;
  longint     fall_cyc;
  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (phase1) begin
        phase1 = 0;
        if (!cas_no) begin
          if (sbq.size() == 0) begin
            chk(0, "R2", "access without request", 1, 0);
          end else begin
            chk(row_rec == sbq[0].addr[15:8], "R2", "row address", row_rec, sbq[0].addr[15:8]);
            chk(ma_o == sbq[0].addr[7:0], "R2", "column address", ma_o, sbq[0].addr[7:0]);
            chk(we_no == !sbq[0].we, "R3", "write enable", we_no, !sbq[0].we);
            if (sbq[0].we) begin
              chk(d_o == sbq[0].wdata, "R3", "write data", d_o, sbq[0].wdata);
              dev[{row_l, ma_o}] = d_o;
            end
            q_i = dev_rd({row_l, ma_o});
          end
        end else begin
          // R6: refresh strobes the row only
          chk(ras_no == 1'b1, "R8", "ras high after refresh", ras_no, 1);
          chk(row_rec[6:0] == exp_row, "R6", "refresh row", row_rec[6:0], exp_row);
          chk(row_rec[7] == 1'b0, "R6", "refresh ma7", row_rec[7], 0);
          if (gap_on && last_ref >= 0)
            chk((fall_cyc - last_ref) == REF_CYCLES, "R5", "refresh spacing", fall_cyc - last_ref, REF_CYCLES);
          last_ref = fall_cyc;
          exp_row = exp_row + 1'b1;
          ref_count++;
        end
      end
      if (!ras_no && prev_ras) begin
        chk(cas_no == 1'b1, "R2", "cas high at ras fall", cas_no, 1);
        row_rec  = ma_o;
        row_l    = ma_o;
        fall_cyc = cyc;
        phase1   = 1;
      end
      if (!cas_no && ras_no) chk(0, "R2", "cas low without ras", cas_no, 1);
      if (!we_no && cas_no) chk(0, "R3", "we low outside column", we_no, 1);
      if (ack_o) begin
        chk(!prev_ack, "R4", "ack width", prev_ack, 0);
        if (sbq.size() == 0) begin
          chk(0, "R4", "spurious ack", 1, 0);
        end else begin
          if (!sbq[0].we) chk(rdata_o == sbq[0].exp, "R4", "read data", rdata_o, sbq[0].exp);
          void'(sbq.pop_front());
        end
      end
      prev_ras = ras_no;
      prev_ack = ack_o;
    end
  end

  task automatic access(bit we, logic [15:0] a, logic [7:0] dat);
    item_t it;
    it.we = we; it.addr = a; it.wdata = dat;
    it.exp = shadow.exists(int'(a)) ? shadow[int'(a)] : 8'h00;
    if (we) shadow[int'(a)] = dat;
    sbq.push_back(it);
    req_i = 1'b1; we_i = we; addr_i = a; wdata_i = dat;
    do @(negedge clk_i); while (!ack_o);
  endtask

  task automatic idle(int n);
    req_i = 1'b0;
    repeat (n) @(negedge clk_i);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int refs0;
    repeat (3) @(negedge clk_i);
    chk(ras_no && cas_no && we_no && !ack_o, "R1", "reset outputs",
        {ras_no, cas_no, we_no, ack_o}, 4'b1110);
    rst_ni = 1'b1;
    repeat (40) @(negedge clk_i);
    chk(ras_no && cas_no && we_no && !ack_o, "R1", "idle outputs",
        {ras_no, cas_no, we_no, ack_o}, 4'b1110);

    // R2 R3 R4: distinct address patterns, readback through the device model
    access(1, 16'h0000, 8'h11);
    access(1, 16'hFFFF, 8'hEE);
    access(1, 16'hA55A, 8'h5A);
    access(1, 16'h5AA5, 8'hA5);
    access(1, 16'h1234, 8'hC3);
    idle(3);
    access(0, 16'h0000, 0);
    access(0, 16'hFFFF, 0);
    access(0, 16'hA55A, 0);
    access(0, 16'h5AA5, 0);
    access(0, 16'h1234, 0);
    access(0, 16'h3412, 0);
    access(0, 16'h7777, 0);
    idle(5);

    // R5: spacing while idle
    last_ref = -1; gap_on = 1;
    idle(REF_CYCLES * 4);
    gap_on = 0;

    // R6: at least 128 more refreshes to pass the wrap
    refs0 = ref_count;
    idle(REF_CYCLES * 131);
    chk((ref_count - refs0) >= 129, "R6", "refreshes through wrap", ref_count - refs0, 129);

    // R7: request held high continuously must not starve refresh
    refs0 = ref_count;
    for (int i = 0; i < 100; i++) access(i[0], 16'(i * 16'h0101 + 16'h0800), 8'(i * 7));
    idle(4);
    chk((ref_count - refs0) >= 4, "R7", "refresh during stream", ref_count - refs0, 4);
    for (int i = 0; i < 100; i += 2) access(0, 16'(i * 16'h0101 + 16'h0800), 0);
    idle(10);
    chk(sbq.size() == 0, "R4", "all accesses acked", sbq.size(), 0);
    finish_run();
  end
endmodule